// File: doc/BRIEF.md
# CAN transmit mailbox scheduler

This block holds three outgoing CAN frames on behalf of a host and decides which one the protocol engine sends next. The host writes a frame into a free slot: identifier, extended flag, remote flag, length code and up to eight data bytes. The write itself marks the slot as wanting transmission. The scheduler offers the most urgent waiting frame to the engine. It moves that slot to in-progress when the engine takes it, and then acts on the outcome of each attempt. An acknowledge frees the slot. A missing acknowledge retries the frame until a programmable number of failed attempts has been used up. A lost arbitration just puts the frame back in the queue.

The host can cancel a slot. A waiting slot is cancelled at once. A slot that is on the wire is cancelled when the current attempt ends. Every transition into a finished state raises a one-cycle completion pulse for that slot. An optional recovery mode returns frames that ran out of retries to the queue once the bus has been quiet for a programmable number of cycles. This covers receivers that were absent for a while. The bit-level engine is outside the block and is reached through an offer/grant/done handshake.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every slot status reads empty, `tx_req` is low and `done_pulse` is all zero.
- R2: Each slot has a 3-bit status at `mb_status[3*i+2:3*i]` with the codes 0 empty, 1 pending, 2 in-progress, 3 done-ok and 4 done-error. A load (`ld_valid` with `ld_idx`) is accepted only when the slot is empty, done-ok or done-error, and the slot becomes pending on the next cycle. A load aimed at a pending or in-progress slot is ignored, and that slot's stored frame stays unchanged.
- R3: While no slot is in progress and some slot is pending, `tx_req` rises within two cycles and presents that slot's index, identifier, flags, length code and data. `tx_req` is low whenever a slot is in progress.
- R4: The offered slot has the lowest priority key among the pending slots. The key is the 29-bit identifier followed by the extended flag as the least significant bit. A standard identifier uses `ld_id[10:0]`, placed in the top 11 of the 29 bits with zeros below. Equal keys go to the lower slot index.
- R5: `tx_grant` while `tx_req` is high moves the offered slot to in-progress. At most one slot is in progress at any time.
- R6: A `tx_done` with `tx_result` 0 (acknowledged) moves the in-progress slot to done-ok.
- R7: A `tx_done` with `tx_result` 1 (no acknowledge) adds one to the slot's retry count. The slot returns to pending until the count reaches `cfg_retry_limit` (at least 1). At that point it goes to done-error.
- R8: A `tx_done` with `tx_result` 2 (arbitration lost) returns the slot to pending and leaves its retry count unchanged.
- R9: `ab_valid` on a pending slot makes it done-error on the next cycle. On an empty or finished slot it has no effect.
- R10: `ab_valid` on an in-progress slot leaves it in progress until `tx_done`. At that point an acknowledge gives done-ok and any other result gives done-error.
- R11: With `cfg_rearm_en` high, a slot that ran out of retries goes back to pending with a cleared count once `bus_idle` has been high for `cfg_idle_limit` consecutive cycles. Slots cancelled by the host are never re-armed, and with `cfg_rearm_en` low no slot is re-armed.
- R12: `done_pulse[i]` is high for exactly one cycle, the first cycle in which slot i shows done-ok or done-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_retry_limit | input | RETRY_W | Failed attempts (no acknowledge) allowed before cancel |
| cfg_rearm_en | input | 1 | Enable re-arm of retry-exhausted frames after bus idle |
| cfg_idle_limit | input | IDLE_W | Consecutive idle cycles needed for re-arm |
| ld_valid | input | 1 | Host load strobe |
| ld_idx | input | $clog2(NUM_MB) | Slot to load |
| ld_id | input | 29 | Identifier (standard in bits 10:0) |
| ld_ext | input | 1 | Extended identifier flag |
| ld_rtr | input | 1 | Remote frame flag |
| ld_dlc | input | 4 | Length code |
| ld_data | input | 64 | Payload bytes |
| ab_valid | input | 1 | Host cancel strobe |
| ab_idx | input | $clog2(NUM_MB) | Slot to cancel |
| bus_idle | input | 1 | Bus idle indication from the engine |
| tx_req | output | 1 | Frame offered to the engine |
| tx_idx | output | $clog2(NUM_MB) | Index of offered slot |
| tx_id | output | 29 | Offered identifier |
| tx_ext | output | 1 | Offered extended flag |
| tx_rtr | output | 1 | Offered remote flag |
| tx_dlc | output | 4 | Offered length code |
| tx_data | output | 64 | Offered payload |
| tx_grant | input | 1 | Engine takes the offered frame |
| tx_done | input | 1 | Attempt finished |
| tx_result | input | 2 | Attempt outcome: 0 ack, 1 no ack, 2 lost |
| mb_status | output | 3*NUM_MB | Per-slot status codes |
| done_pulse | output | NUM_MB | Per-slot completion pulse |

## Verification
The bench drives mixes of standard and extended identifiers, including equal keys. A selector that compared raw identifiers, ignored the extended bit, or broke ties upward would offer the wrong slot. It interleaves lost arbitrations with missing acknowledges, so a counter that also charged lost attempts would cancel a frame too early. A counter off by one would cancel it a step early or late. Cancels are aimed at waiting, on-the-wire and finished slots. Applying a cancel at once to an on-the-wire slot would tear it out of progress, and honouring one on a finished slot would emit a stray pulse. The recovery timer is watched before and after its interval, with host-cancelled and disabled cases, to expose early firing or re-arming of the wrong slots.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int KEY_W  = ID_W + 1;

  typedef enum logic [2:0] {
    MB_EMPTY = 3'd0,
    MB_PEND  = 3'd1,
    MB_BUSY  = 3'd2,
    MB_OK    = 3'd3,
    MB_ERR   = 3'd4
  } mb_state_e;

  typedef enum logic [1:0] {
    RES_ACK  = 2'd0,
    RES_NACK = 2'd1,
    RES_LOST = 2'd2,
    RES_RSVD = 2'd3
  } tx_res_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Arbitration-order key: smaller value wins on the wire.
  function automatic logic [KEY_W-1:0] prio_key(input logic [ID_W-1:0] id, input logic ext);
    if (ext) return {id, 1'b1};
    return {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}, 1'b0};
  endfunction
endpackage

// File: rtl/can_txmb_store.sv
module can_txmb_store
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int AW     = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  frame_t        wdata,
  input  logic [AW-1:0] raddr,
  output frame_t        rdata
);
  // Frame storage with synchronous read so that RAM can be inferred.
  frame_t mem [NUM_MB];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_txmb_sel.sv
module can_txmb_sel
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int AW     = 2
) (
  input  logic [NUM_MB-1:0] elig,
  input  logic [KEY_W-1:0]  keys [NUM_MB],
  output logic              any,
  output logic [AW-1:0]     idx
);
  logic [KEY_W-1:0] best;

  // Scan from the top index down; "<=" lets a lower index take ties.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (elig[i] && (!any || keys[i] <= best)) begin
        any  = 1'b1;
        idx  = AW'(i);
        best = keys[i];
      end
    end
  end
endmodule

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_hit,
  input  logic [KEY_W-1:0]   key_in,
  input  logic               ab_hit,
  input  logic               grant_hit,
  input  logic               done_hit,
  input  logic [1:0]         result,
  input  logic               rearm_fire,
  input  logic [RETRY_W-1:0] retry_limit,
  output mb_state_e          st,
  output logic               pulse,
  output logic [KEY_W-1:0]   key
);
  logic [RETRY_W-1:0] cnt;
  logic [RETRY_W:0]   cnt_nxt;
  logic               abort_q;
  logic               rearm_ok;
  logic               exhaust;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign exhaust = cnt_nxt >= {1'b0, retry_limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= MB_EMPTY;
      cnt      <= '0;
      abort_q  <= 1'b0;
      rearm_ok <= 1'b0;
      pulse    <= 1'b0;
      key      <= '0;
    end else begin
      pulse <= 1'b0;
      case (st)
        MB_EMPTY, MB_OK, MB_ERR: begin
          if (ld_hit) begin
            st       <= MB_PEND;
            cnt      <= '0;
            abort_q  <= 1'b0;
            rearm_ok <= 1'b0;
            key      <= key_in;
          end else if (st == MB_ERR && rearm_ok && rearm_fire) begin
            st       <= MB_PEND;
            cnt      <= '0;
            rearm_ok <= 1'b0;
          end
        end
        MB_PEND: begin
          if (ab_hit) begin
            st    <= MB_ERR;
            pulse <= 1'b1;
          end else if (grant_hit) begin
            st <= MB_BUSY;
          end
        end
        MB_BUSY: begin
          if (done_hit) begin
            abort_q <= 1'b0;
            if (tx_res_e'(result) == RES_ACK) begin
              st    <= MB_OK;
              pulse <= 1'b1;
            end else if (abort_q || ab_hit) begin
              st    <= MB_ERR;
              pulse <= 1'b1;
            end else if (tx_res_e'(result) == RES_LOST) begin
              st <= MB_PEND;
            end else if (exhaust) begin
              st       <= MB_ERR;
              pulse    <= 1'b1;
              rearm_ok <= 1'b1;
            end else begin
              cnt <= cnt_nxt[RETRY_W-1:0];
              st  <= MB_PEND;
            end
          end else if (ab_hit) begin
            abort_q <= 1'b1;
          end
        end
        default: st <= MB_EMPTY;
      endcase
    end
  end

  // R9
  abort_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MB_PEND && ab_hit) |=> (st == MB_ERR && pulse));

  // R10
  defer_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MB_BUSY && ab_hit && !done_hit) |=> (st == MB_BUSY));

  // R8
  lost_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MB_BUSY && done_hit && result == 2'd2 && !ab_hit && !abort_q)
      |=> (st == MB_PEND && cnt == $past(cnt)));

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB  = 3,
  parameter int RETRY_W = 4,
  parameter int IDLE_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [RETRY_W-1:0]         cfg_retry_limit,
  input  logic                       cfg_rearm_en,
  input  logic [IDLE_W-1:0]          cfg_idle_limit,
  input  logic                       ld_valid,
  input  logic [$clog2(NUM_MB)-1:0]  ld_idx,
  input  logic [28:0]                ld_id,
  input  logic                       ld_ext,
  input  logic                       ld_rtr,
  input  logic [3:0]                 ld_dlc,
  input  logic [63:0]                ld_data,
  input  logic                       ab_valid,
  input  logic [$clog2(NUM_MB)-1:0]  ab_idx,
  input  logic                       bus_idle,
  output logic                       tx_req,
  output logic [$clog2(NUM_MB)-1:0]  tx_idx,
  output logic [28:0]                tx_id,
  output logic                       tx_ext,
  output logic                       tx_rtr,
  output logic [3:0]                 tx_dlc,
  output logic [63:0]                tx_data,
  input  logic                       tx_grant,
  input  logic                       tx_done,
  input  logic [1:0]                 tx_result,
  output logic [3*NUM_MB-1:0]        mb_status,
  output logic [NUM_MB-1:0]          done_pulse
);
  localparam int AW = $clog2(NUM_MB);

  mb_state_e          st    [NUM_MB];
  logic [KEY_W-1:0]   keys  [NUM_MB];
  logic [NUM_MB-1:0]  ld_hit, ab_hit, grant_hit, done_hit, elig, busy, pulse;
  logic               ld_ok, grant_fire, sel_any, rearm_fire;
  logic [AW-1:0]      sel_idx;
  logic [IDLE_W-1:0]  idle_cnt;
  frame_t             wr_frame, rd_frame;

  assign grant_fire = tx_grant && tx_req;
  assign wr_frame   = '{id: ld_id, ext: ld_ext, rtr: ld_rtr, dlc: ld_dlc, data: ld_data};

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      ld_hit[i]    = ld_valid && (ld_idx == AW'(i)) &&
                     (st[i] == MB_EMPTY || st[i] == MB_OK || st[i] == MB_ERR);
      ab_hit[i]    = ab_valid && (ab_idx == AW'(i));
      busy[i]      = (st[i] == MB_BUSY);
      elig[i]      = (st[i] == MB_PEND) && !ab_hit[i];
      grant_hit[i] = grant_fire && (tx_idx == AW'(i));
      done_hit[i]  = tx_done && busy[i];
    end
  end
  assign ld_ok = |ld_hit;

  // Bus-idle interval timer for re-arming exhausted frames.
  assign rearm_fire = cfg_rearm_en && bus_idle && (idle_cnt >= cfg_idle_limit);

  always_ff @(posedge clk) begin
    if (rst || !bus_idle || rearm_fire) idle_cnt <= '0;
    else if (idle_cnt != {IDLE_W{1'b1}}) idle_cnt <= idle_cnt + 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MB; g++) begin : g_slot
      can_txmb_slot #(.RETRY_W(RETRY_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .ld_hit     (ld_hit[g]),
        .key_in     (prio_key(ld_id, ld_ext)),
        .ab_hit     (ab_hit[g]),
        .grant_hit  (grant_hit[g]),
        .done_hit   (done_hit[g]),
        .result     (tx_result),
        .rearm_fire (rearm_fire),
        .retry_limit(cfg_retry_limit),
        .st         (st[g]),
        .pulse      (pulse[g]),
        .key        (keys[g])
      );
      assign mb_status[3*g +: 3] = st[g];
      assign done_pulse[g]       = pulse[g];
    end
  endgenerate

  can_txmb_sel #(.NUM_MB(NUM_MB), .AW(AW)) u_sel (
    .elig (elig),
    .keys (keys),
    .any  (sel_any),
    .idx  (sel_idx)
  );

  can_txmb_store #(.NUM_MB(NUM_MB), .AW(AW)) u_store (
    .clk   (clk),
    .we    (ld_ok),
    .waddr (ld_idx),
    .wdata (wr_frame),
    .raddr (sel_idx),
    .rdata (rd_frame)
  );

  // Registered offer; held off for the cycle a grant is being taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      tx_idx <= '0;
    end else begin
      tx_req <= sel_any && !(|busy) && !grant_fire;
      tx_idx <= sel_idx;
    end
  end

  assign tx_id   = rd_frame.id;
  assign tx_ext  = rd_frame.ext;
  assign tx_rtr  = rd_frame.rtr;
  assign tx_dlc  = rd_frame.dlc;
  assign tx_data = rd_frame.data;

  // R5
  one_inprog_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy));

  // R3
  req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (busy == '0));

  // R6
  ack_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done && busy != '0 && tx_result == 2'd0) |=> (busy == '0 && done_pulse != '0));
endmodule

// File: tb/tb_can_txmb_sched.sv
`timescale 1ns/1ps
module tb_can_txmb_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_retry_limit = 4'd3;
  logic        cfg_rearm_en = 1'b0;
  logic [15:0] cfg_idle_limit = 16'd40;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_idx = '0;
  logic [28:0] ld_id = '0;
  logic        ld_ext = 1'b0, ld_rtr = 1'b0;
  logic [3:0]  ld_dlc = '0;
  logic [63:0] ld_data = '0;
  logic        ab_valid = 1'b0;
  logic [1:0]  ab_idx = '0;
  logic        bus_idle = 1'b0;
  logic        tx_req, tx_ext, tx_rtr;
  logic [1:0]  tx_idx;
  logic [28:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_grant = 1'b0, tx_done = 1'b0;
  logic [1:0]  tx_result = '0;
  logic [8:0]  mb_status;
  logic [2:0]  done_pulse;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [28:0] b_id [3];
  logic        b_ext [3];
  logic [3:0]  b_dlc [3];
  logic [63:0] b_data [3];
  bit          rem [3];

  always #4 clk = ~clk;

  can_txmb_sched dut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] stat(input int i);
    return mb_status[3*i +: 3];
  endfunction

  function automatic logic [29:0] exp_key(input logic [28:0] id, input bit ext);
    return ext ? {id, 1'b1} : {id[10:0], 18'd0, 1'b0};
  endfunction

  task automatic load_mb(input int idx, input logic [28:0] id, input bit ext,
                         input logic [3:0] dlc, input logic [63:0] d);
    ld_valid = 1'b1; ld_idx = 2'(idx); ld_id = id; ld_ext = ext;
    ld_rtr = 1'b0; ld_dlc = dlc; ld_data = d;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic abort_mb(input int idx);
    ab_valid = 1'b1; ab_idx = 2'(idx);
    tick();
    ab_valid = 1'b0;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 8 && !tx_req; k++) tick();
  endtask

  task automatic grant();
    tx_grant = 1'b1;
    tick();
    tx_grant = 1'b0;
  endtask

  task automatic finish_try(input logic [1:0] res);
    tx_done = 1'b1; tx_result = res;
    tick();
    tx_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (5) tick();
    rst = 1'b0;

    // R1: reset state
    check(mb_status == 9'd0, "R1 status", 64'(mb_status), 0);
    check(tx_req == 1'b0, "R1 tx_req", 64'(tx_req), 0);
    check(done_pulse == 3'd0, "R1 pulse", 64'(done_pulse), 0);

    // R2/R3: basic load and offer
    load_mb(1, 29'h123, 1'b0, 4'd8, 64'h0102030405060708);
    check(stat(1) == 3'd1, "R2 load->pending", 64'(stat(1)), 1);
    tick(); tick();
    check(tx_req && tx_idx == 2'd1, "R3 offer idx", 64'(tx_idx), 1);
    check(tx_id == 29'h123 && tx_dlc == 4'd8, "R3 offer id", 64'(tx_id), 64'h123);
    check(tx_data == 64'h0102030405060708, "R3 offer data", tx_data, 64'h0102030405060708);
    load_mb(1, 29'h7FF, 1'b0, 4'd1, 64'hDEAD);
    tick(); tick();
    check(tx_id == 29'h123 && tx_data == 64'h0102030405060708, "R2 load on pending ignored",
          64'(tx_id), 64'h123);
    grant();
    check(stat(1) == 3'd2, "R5 grant->inprog", 64'(stat(1)), 2);
    tick();
    check(tx_req == 1'b0, "R3 no offer while busy", 64'(tx_req), 0);
    load_mb(1, 29'h55, 1'b0, 4'd1, 64'h1);
    check(stat(1) == 3'd2, "R2 load on inprog ignored", 64'(stat(1)), 2);
    finish_try(2'd0);
    check(stat(1) == 3'd3, "R6 ack->done ok", 64'(stat(1)), 3);
    check(done_pulse == 3'b010, "R12 pulse on done", 64'(done_pulse), 2);
    tick();
    check(done_pulse == 3'b000, "R12 pulse one cycle", 64'(done_pulse), 0);

    // R7: retry exhaustion after three missing acks
    cfg_retry_limit = 4'd3;
    load_mb(0, 29'h10, 1'b0, 4'd0, 64'h0);
    for (int k = 1; k <= 3; k++) begin
      wait_req(); grant(); finish_try(2'd1);
      if (k < 3) begin
        check(stat(0) == 3'd1, "R7 retry pending", 64'(stat(0)), 1);
        check(done_pulse == 3'd0, "R7 no pulse on retry", 64'(done_pulse), 0);
      end else begin
        check(stat(0) == 3'd4, "R7 exhausted", 64'(stat(0)), 4);
        check(done_pulse == 3'b001, "R12 pulse on error", 64'(done_pulse), 1);
      end
    end

    // R8: lost arbitration does not consume retries
    cfg_retry_limit = 4'd2;
    load_mb(2, 29'h1ABCDE, 1'b1, 4'd2, 64'hAA);
    for (int k = 0; k < 4; k++) begin
      wait_req(); grant(); finish_try(2'd2);
      check(stat(2) == 3'd1, "R8 lost->pending", 64'(stat(2)), 1);
    end
    wait_req(); grant(); finish_try(2'd1);
    check(stat(2) == 3'd1, "R8 count unchanged by lost", 64'(stat(2)), 1);
    wait_req(); grant(); finish_try(2'd1);
    check(stat(2) == 3'd4, "R7 limit two", 64'(stat(2)), 4);

    // R9: abort on pending and on finished slots
    cfg_retry_limit = 4'd3;
    load_mb(0, 29'h20, 1'b0, 4'd1, 64'h5);
    abort_mb(0);
    check(stat(0) == 3'd4 && done_pulse == 3'b001, "R9 abort pending", 64'(stat(0)), 4);
    abort_mb(0);
    check(stat(0) == 3'd4 && done_pulse == 3'b000, "R9 abort done ignored", 64'(done_pulse), 0);
    abort_mb(1);
    check(stat(1) == 3'd3 && done_pulse == 3'b000, "R9 abort done-ok ignored", 64'(stat(1)), 3);

    // R10: deferred abort of the frame on the wire
    load_mb(0, 29'h21, 1'b0, 4'd1, 64'h6);
    wait_req(); grant(); abort_mb(0);
    check(stat(0) == 3'd2, "R10 abort waits", 64'(stat(0)), 2);
    finish_try(2'd1);
    check(stat(0) == 3'd4, "R10 nack after abort->error", 64'(stat(0)), 4);
    load_mb(0, 29'h22, 1'b0, 4'd1, 64'h7);
    wait_req(); grant(); abort_mb(0);
    finish_try(2'd0);
    check(stat(0) == 3'd3, "R10 ack after abort->ok", 64'(stat(0)), 3);

    // R11: re-arm after a long idle interval
    cfg_retry_limit = 4'd1; cfg_rearm_en = 1'b1; cfg_idle_limit = 16'd40;
    load_mb(1, 29'h30, 1'b0, 4'd1, 64'h8);
    wait_req(); grant(); finish_try(2'd1);
    check(stat(1) == 3'd4, "R7 limit one", 64'(stat(1)), 4);
    load_mb(2, 29'h31, 1'b0, 4'd1, 64'h9);
    abort_mb(2);
    bus_idle = 1'b1;
    repeat (20) tick();
    check(stat(1) == 3'd4, "R11 not before interval", 64'(stat(1)), 4);
    repeat (30) tick();
    check(stat(1) == 3'd1, "R11 rearmed", 64'(stat(1)), 1);
    check(stat(2) == 3'd4, "R11 host abort not rearmed", 64'(stat(2)), 4);
    bus_idle = 1'b0;
    wait_req();
    check(tx_req && tx_idx == 2'd1, "R11 rearmed offered", 64'(tx_idx), 1);
    grant(); finish_try(2'd0);
    cfg_rearm_en = 1'b0;
    load_mb(1, 29'h32, 1'b0, 4'd1, 64'hA);
    wait_req(); grant(); finish_try(2'd1);
    bus_idle = 1'b1;
    repeat (100) tick();
    check(stat(1) == 3'd4, "R11 disabled no rearm", 64'(stat(1)), 4);
    bus_idle = 1'b0;
    tick();

    // R4: random priority rounds
    cfg_retry_limit = 4'd3;
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < 3; i++) begin
        b_ext[i] = 1'($urandom % 2);
        if (r % 5 == 4) b_ext[i] = 1'b0;
        b_id[i] = b_ext[i] ? 29'($urandom) : 29'($urandom % 2048);
        if (r % 5 == 4) b_id[i] = 29'h2A5;
        b_dlc[i] = 4'($urandom % 9);
        b_data[i] = {32'($urandom), 32'($urandom)};
        rem[i] = 1'b1;
        load_mb(i, b_id[i], b_ext[i], b_dlc[i], b_data[i]);
      end
      tick(); tick();
      for (int n = 0; n < 3; n++) begin
        int e;
        e = -1;
        for (int i = 0; i < 3; i++)
          if (rem[i] && (e < 0 || exp_key(b_id[i], b_ext[i]) < exp_key(b_id[e], b_ext[e]))) e = i;
        wait_req();
        check(tx_req && tx_idx == 2'(e), "R4 priority order", 64'(tx_idx), 64'(e));
        check(tx_id == b_id[e] && tx_ext == b_ext[e], "R3 offered id", 64'(tx_id), 64'(b_id[e]));
        check(tx_data == b_data[e] && tx_dlc == b_dlc[e], "R3 offered data", tx_data, b_data[e]);
        if ($urandom % 3 == 0) begin
          grant(); finish_try(2'd2);
          check(stat(e) == 3'd1, "R8 lost re-queued", 64'(stat(e)), 1);
          wait_req();
          check(tx_idx == 2'(e), "R4 same winner after loss", 64'(tx_idx), 64'(e));
        end
        grant(); finish_try(2'd0);
        check(stat(e) == 3'd3, "R6 ack", 64'(stat(e)), 3);
        check(done_pulse == 3'(1 << e), "R12 pulse slot", 64'(done_pulse), 64'(1 << e));
        rem[e] = 1'b0;
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule